// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor Core

This block is a complete processor with a single instruction. It holds a one-word accumulator, a program counter and a private word-addressed memory. Every instruction takes two consecutive memory words. The first word holds an operand address and the second holds a branch target. The core forms the operand value minus the accumulator. It stores that difference both in the accumulator and back into the operand word. If the difference is negative, it jumps to the target. Otherwise it carries on at the word after the instruction. There are no other opcodes, and the fetch-execute loop never stops by itself.

Software prepares a run by holding reset and writing the program and data through the load port. It then releases reset and waits for `halted`. `halted` rises when a taken branch points back at the instruction that just ran, which is the usual idiom for the end of a program. After the halt, the debug address selects a memory word and its contents appear on `dbg_word` one clock later. The accumulator and program counter are visible on their own ports at all times.

The core runs as a five-state machine over one single-port synchronous memory:
- `ST_FETCH_OP` reads the word at pc and then always goes to `ST_FETCH_DST`.
- `ST_FETCH_DST` captures the operand address, reads pc+1 and always goes to `ST_READ_OPND`.
- `ST_READ_OPND` captures the target, reads the operand, steps pc by two and always goes to `ST_EXEC`.
- `ST_EXEC` subtracts and writes back. It goes to `ST_HALT` when the branch is taken and the target equals the instruction's own address; otherwise it returns to `ST_FETCH_OP`.
- `ST_HALT` is left only by reset.

Top module: `sbn_core`

## Requirements
- R1: A clock edge with `rst` high clears `acc` and `pc` to 0 and leaves `halted` low. While `rst` is high, a clock edge with `load_en` high writes `load_data` into the word at `load_addr`.
- R2: In each instruction, the word at pc supplies the operand address in its low 8 bits. The word at pc+1 supplies the branch target in its low 8 bits.
- R3: The instruction computes the operand word minus `acc`, modulo 2^16, and loads the result into `acc`.
- R4: The same difference is written back to the operand's memory word in the same cycle.
- R5: If bit 15 of the difference is 1, `pc` becomes the target. Otherwise `pc` stays at the instruction address plus 2.
- R6: Every instruction takes exactly four clocks. `pc` gains 2 at the third edge. `acc`, memory and any branch change only at the fourth edge.
- R7: A taken branch whose target equals the address of the instruction that produced it raises `halted`. From then until reset, `halted` stays high and `acc`, `pc` and memory do not change.
- R8: While `halted` is high, `dbg_word` shows the memory word at `dbg_addr` one clock after `dbg_addr` is applied.
- R9: `load_en` has no effect while `rst` is low, so no memory word changes through the load port during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also enables loading |
| load_en | input | 1 | Memory write strobe for loading, honoured only during reset |
| load_addr | input | 8 | Word address for loading |
| load_data | input | 16 | Word to load |
| dbg_addr | input | 8 | Word address for debug read-out after halt |
| dbg_word | output | 16 | Memory word read through the debug address |
| acc | output | 16 | Accumulator |
| pc | output | 8 | Program counter |
| halted | output | 1 | High once the program has branched to itself |

## Verification
In the execute cycle, three things happen on one edge: the memory write-back, the accumulator update and the halt decision. The worst case is a halting instruction whose operand is its own first word. In that case the final store lands in the word that was just fetched as code, at the same moment the machine stops. One bench program ends this way. After the halt, every memory word is read through the debug port and compared with a behavioural model. This shows that the last store was not lost to the halt. A second program uses a difference that overflows from positive to negative, which exercises the branch decision based on the sign bit. Across both runs, accumulator, program counter and halt flag are compared with the model on every clock.

// File: rtl/sbn_pkg.sv
package sbn_pkg;

    // Controller states; one instruction walks through the first four.
    typedef enum logic [2:0] {
        ST_FETCH_OP  = 3'd0,
        ST_FETCH_DST = 3'd1,
        ST_READ_OPND = 3'd2,
        ST_EXEC      = 3'd3,
        ST_HALT      = 3'd4
    } sbn_state_t;

endpackage

// File: rtl/sbn_mem.sv
// Single-port synchronous word memory with registered read (old data on write).
module sbn_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end
endmodule

// File: rtl/sbn_sub.sv
// Operand-minus-accumulator subtractor with sign flag.
module sbn_sub #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] accum,
    output logic [DW-1:0] diff,
    output logic          neg
);
    always_comb begin
        diff = opnd - accum;
        neg  = diff[DW-1];
    end
endmodule

// File: rtl/sbn_ctrl.sv
// Instruction sequencer: state register, output decode and architectural registers.
module sbn_ctrl
    import sbn_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] diff,
    input  logic          neg,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] dst,
    output sbn_state_t    state,
    output logic          halted
);
    localparam logic [AW-1:0] STEP_ONE = AW'(1);
    localparam logic [AW-1:0] STEP_TWO = AW'(2);

    sbn_state_t    nxt;
    logic [AW-1:0] opa_q;
    logic [AW-1:0] dst_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] acc_q;
    logic          self_loop;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH_OP;
        end else begin
            state <= nxt;
        end
    end

    // In ST_EXEC pc already holds the instruction address plus two.
    assign self_loop = (dst_q == (pc_q - STEP_TWO));

    // Next state and memory-port outputs
    always_comb begin
        nxt       = state;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = diff;
        unique case (state)
            ST_FETCH_OP: begin
                mem_addr = pc_q;
                nxt      = ST_FETCH_DST;
            end
            ST_FETCH_DST: begin
                mem_addr = pc_q + STEP_ONE;
                nxt      = ST_READ_OPND;
            end
            ST_READ_OPND: begin
                mem_addr = opa_q;
                nxt      = ST_EXEC;
            end
            ST_EXEC: begin
                mem_addr = opa_q;
                mem_we   = 1'b1;
                nxt      = (neg && self_loop) ? ST_HALT : ST_FETCH_OP;
            end
            ST_HALT: begin
                nxt = ST_HALT;
            end
            default: begin
                nxt = ST_FETCH_OP;
            end
        endcase
    end

    // Architectural and instruction registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            acc_q <= '0;
            opa_q <= '0;
            dst_q <= '0;
        end else begin
            case (state)
                ST_FETCH_DST: opa_q <= rdata[AW-1:0];
                ST_READ_OPND: begin
                    dst_q <= rdata[AW-1:0];
                    pc_q  <= pc_q + STEP_TWO;
                end
                ST_EXEC: begin
                    acc_q <= diff;
                    if (neg) begin
                        pc_q <= dst_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign pc     = pc_q;
    assign acc    = acc_q;
    assign dst    = dst_q;
    assign halted = (state == ST_HALT);
endmodule

// File: rtl/sbn_core.sv
module sbn_core
    import sbn_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_word,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic          halted
);
    logic [DW-1:0] rdata;
    logic [DW-1:0] diff;
    logic          neg;
    logic [AW-1:0] c_addr;
    logic          c_we;
    logic [DW-1:0] c_wdata;
    logic [AW-1:0] c_dst;
    sbn_state_t    st;

    logic [AW-1:0] m_addr;
    logic          m_we;
    logic [DW-1:0] m_wdata;

    sbn_sub #(.DW(DW)) sub_i (
        .opnd  (rdata),
        .accum (acc),
        .diff  (diff),
        .neg   (neg)
    );

    sbn_ctrl #(.DW(DW), .AW(AW)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .rdata     (rdata),
        .diff      (diff),
        .neg       (neg),
        .mem_addr  (c_addr),
        .mem_we    (c_we),
        .mem_wdata (c_wdata),
        .pc        (pc),
        .acc       (acc),
        .dst       (c_dst),
        .state     (st),
        .halted    (halted)
    );

    // Port owner: loader during reset, debug after halt, sequencer otherwise.
    always_comb begin
        if (rst) begin
            m_addr  = load_addr;
            m_we    = load_en;
            m_wdata = load_data;
        end else if (halted) begin
            m_addr  = dbg_addr;
            m_we    = 1'b0;
            m_wdata = c_wdata;
        end else begin
            m_addr  = c_addr;
            m_we    = c_we;
            m_wdata = c_wdata;
        end
    end

    sbn_mem #(.DW(DW), .AW(AW)) mem_i (
        .clk   (clk),
        .we    (m_we),
        .addr  (m_addr),
        .wdata (m_wdata),
        .rdata (rdata)
    );

    assign dbg_word = rdata;
endmodule

// File: rtl/sbn_core_chk.sv
module sbn_core_chk
    import sbn_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          halted,
    input logic [AW-1:0] pc,
    input logic [DW-1:0] acc,
    input sbn_state_t    st,
    input logic          c_we,
    input logic [DW-1:0] c_wdata,
    input logic [AW-1:0] c_dst
);
    localparam logic [AW-1:0] STEP_TWO = AW'(2);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc == '0 && !halted));

    p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ_OPND) |=> (pc == $past(pc) + STEP_TWO));

    p_acc_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (st != ST_EXEC) |=> $stable(acc));

    // R3 and R4: accumulator receives exactly the word stored to memory
    p_wb_match_r4: assert property (@(posedge clk) disable iff (rst)
        c_we |=> (acc == $past(c_wdata)));

    p_branch_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && c_wdata[DW-1]) |=> (pc == $past(c_dst)));

    p_branch_not_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && !c_wdata[DW-1]) |=> $stable(pc));

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && $stable(acc)));
endmodule

bind sbn_core sbn_core_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .halted  (halted),
    .pc      (pc),
    .acc     (acc),
    .st      (st),
    .c_we    (c_we),
    .c_wdata (c_wdata),
    .c_dst   (c_dst)
);

// File: tb/sbn_core_tb_top.sv
`timescale 1ns/1ps
module sbn_core_tb_top;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic [AW-1:0] dbg_addr = '0;
    logic [DW-1:0] dbg_word;
    logic [DW-1:0] acc;
    logic [AW-1:0] pc;
    logic          halted;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference model
    logic [DW-1:0] img   [WORDS];
    logic [DW-1:0] m_mem [WORDS];
    logic [AW-1:0] m_pc, m_oa, m_dst;
    logic [DW-1:0] m_ac;
    bit            m_halt;
    int            ph;

    always #5 clk = ~clk;

    sbn_core #(.DW(DW), .AW(AW)) dut_i (
        .clk, .rst, .load_en, .load_addr, .load_data,
        .dbg_addr, .dbg_word, .acc, .pc, .halted
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input int v);
        img[a] = v[DW-1:0];
    endtask

    // R1: load image while reset held, then check reset state
    task automatic load_and_reset();
        for (int a = 0; a < WORDS; a++) begin
            @(negedge clk);
            rst = 1'b1; load_en = 1'b1;
            load_addr = a[AW-1:0]; load_data = img[a];
            m_mem[a] = img[a];
        end
        @(negedge clk);
        load_en = 1'b0;
        @(posedge clk); #2;
        chk(pc == 0, "R1 pc after reset", pc, 0);
        chk(acc == 0, "R1 acc after reset", acc, 0);
        chk(!halted, "R1 halted after reset", halted, 0);
        m_pc = '0; m_ac = '0; m_halt = 1'b0; ph = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One clock edge of the reference machine (R2, R3, R4, R5, R6, R7)
    task automatic model_edge();
        logic [DW-1:0] d;
        if (m_halt) return;
        case (ph)
            0: begin
                m_oa  = m_mem[m_pc][AW-1:0];
                m_dst = m_mem[m_pc + 8'd1][AW-1:0];
                ph = 1;
            end
            1: ph = 2;
            2: begin m_pc = m_pc + 8'd2; ph = 3; end
            default: begin
                d = m_mem[m_oa] - m_ac;
                m_mem[m_oa] = d;
                m_ac = d;
                if (d[DW-1]) begin
                    if (m_dst == m_pc - 8'd2) m_halt = 1'b1;
                    m_pc = m_dst;
                end
                ph = 0;
            end
        endcase
    endtask

    task automatic run(input int poke_cycle);
        int tail = 0;
        for (int c = 0; c < 4000; c++) begin
            if (c == poke_cycle) begin
                // R9: load strobe during a run must be ignored
                load_en = 1'b1; load_addr = 8'h90; load_data = 16'hBEEF;
            end else begin
                load_en = 1'b0;
            end
            @(posedge clk);
            model_edge();
            #2;
            chk(pc == m_pc, "R2 R5 R6 pc", pc, m_pc);
            chk(acc == m_ac, "R3 R6 acc", acc, m_ac);
            chk(halted == m_halt, "R7 halted", halted, m_halt);
            if (m_halt) tail++;
            if (tail > 3) break;
            @(negedge clk);
        end
        load_en = 1'b0;
        chk(halted, "R7 program reached halt", halted, 1);
    endtask

    // R4, R8: full memory comparison through the debug port
    task automatic dump_check();
        for (int a = 0; a < WORDS; a++) begin
            @(negedge clk);
            dbg_addr = a[AW-1:0];
            @(posedge clk); #2;
            chk(dbg_word == m_mem[a], "R4 R8 memory word", dbg_word, m_mem[a]);
        end
    endtask

    task automatic dbg_one(input int a, input int exp, input string tag);
        @(negedge clk);
        dbg_addr = a[AW-1:0];
        @(posedge clk); #2;
        chk(dbg_word == exp[DW-1:0], tag, dbg_word, exp);
    endtask

    initial begin
        // Program A: non-taken, taken, overflowing subtract, halt
        for (int a = 0; a < WORDS; a++) img[a] = '0;
        put(8'h00, 8'h40); put(8'h01, 8'h10);
        put(8'h02, 8'h41); put(8'h03, 8'h20);
        put(8'h20, 8'h42); put(8'h21, 8'h30);
        put(8'h30, 8'h43); put(8'h31, 8'h36);
        put(8'h36, 8'h44); put(8'h37, 8'h00);
        put(8'h38, 8'h45); put(8'h39, 8'h38);
        put(8'h40, 5); put(8'h41, 3); put(8'h42, 16'h7FFF); put(8'h43, 16'h8000);
        load_and_reset();
        run(6);
        chk(acc == 16'hFFFF, "R3 final acc program A", acc, 16'hFFFF);
        chk(pc == 8'h38, "R7 halt pc program A", pc, 8'h38);
        dbg_one(8'h90, 0, "R9 load ignored during run");
        dbg_one(8'h42, 16'h8001, "R4 overflowed difference stored");
        dump_check();

        // Program B: halting instruction uses its own word as operand
        for (int a = 0; a < WORDS; a++) img[a] = '0;
        put(8'h00, 8'h50); put(8'h01, 8'hFC);
        put(8'h02, 8'h51); put(8'h03, 8'hFC);
        put(8'hFC, 8'h52); put(8'hFD, 8'h00);
        put(8'hFE, 8'hFE); put(8'hFF, 8'hFE);
        put(8'h50, 16'h0100); put(8'h51, 16'h0080); put(8'h52, 16'h0080);
        load_and_reset();
        run(-1);
        chk(pc == 8'hFE, "R7 halt pc program B", pc, 8'hFE);
        dbg_one(8'hFE, 16'hFFFE, "R4 write-back in halting cycle");
        dump_check();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule